// File: doc/BRIEF.md
# Character Pixel Serializer with Bus-Snooped Codes

This block produces a serial monochrome pixel stream from character codes that a CPU places on its data bus during instruction fetch. It holds a 2048-byte glyph memory. The memory is addressed by a 7-bit character code taken from the bus and by a 4-bit scan-row number. Software sets the scan row before each row of pixels is drawn. An 8-bit parallel-load register shifts the fetched glyph byte out one pixel per pixel clock, most significant bit first. A value of 1 on the output means a black pixel and 0 means a white pixel.

The block has no video address counter. The reload of the pixel register is timed only by the CPU's own bus cycle. Load logic watches the active-low memory-request and refresh signals and the CPU clock, which runs at half the pixel rate. The load strobe is active while all three are low. In an opcode-fetch cycle, which spans 8 pixel clocks, this happens for exactly one pixel clock edge. The byte on the bus at that edge is the character whose glyph row is loaded. The glyph memory is filled through a plain write port.

Top module: `charpix_serializer`

## Requirements
- R1: When `rom_we` is 1 at a rising `clk_pix` edge, the glyph memory stores `rom_wdata` at `rom_waddr`, and later loads of that address return the new byte.
- R2: When `row_we` is 1 at a rising edge, the scan-row latch takes `row_wdata`. Otherwise it holds its value. A new row affects only loads at later edges.
- R3: The glyph byte loaded is the memory byte at address `{scan_row, cpu_data}`: the row in bits 10:7 and the character code in bits 6:0.
- R4: At a rising edge where the load strobe is active, the pixel register takes the glyph byte in parallel, and `pix_out` shows bit 7 of that byte from that edge on.
- R5: The load strobe is active exactly when `mreq_n`, `rfsh_n` and `cpu_clk` are all 0. If any of them is 1, no load takes place.
- R6: At every rising edge without a load, the register shifts toward its most significant bit and takes 0 at bit 0. The pixels of a loaded byte therefore appear from bit 7 down to bit 0, one per clock.
- R7: After 8 or more edges without a load, `pix_out` is 0 (white) until the next load.
- R8: While `rst_n` is low, the pixel register and the scan-row latch are cleared at once. `pix_out` is 0 during that time, and the row is 0 after reset.
- R9: With one load every 8 pixel clocks, the glyph bytes of successive characters follow each other with no gap pixel and no repeated pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_data | input | CODE_W (7) | Low CPU data bus lines, used as the character code |
| mreq_n | input | 1 | CPU memory request, active low |
| rfsh_n | input | 1 | CPU refresh indication, active low |
| cpu_clk | input | 1 | CPU clock at half the pixel rate, sampled at the pixel clock |
| row_we | input | 1 | Scan-row latch write strobe |
| row_wdata | input | ROW_W (4) | New scan-row number |
| rom_we | input | 1 | Glyph memory write enable |
| rom_waddr | input | ROW_W+CODE_W (11) | Glyph memory write address, laid out as in R3 |
| rom_wdata | input | BYTE_W (8) | Glyph memory write data |
| pix_out | output | 1 | Serial pixel, 1 = black, 0 = white |

## Verification
The bench uses the default parameters: a 7-bit code, a 4-bit row and an 8-pixel group. With these, every one of the 2048 glyph addresses can be written and compared against a value computed in the bench, and all 16 scan rows can be reached. The bench drives fetch cycles 8 clocks long, aligned to the CPU clock. It also drives cycles that would almost load: refresh held high, or the CPU clock held high while both strobes are low. These show that the load happens on exactly one edge, that pixels run on without a break from one character to the next, and that the output turns white once the register is empty.

// File: rtl/charpix_pkg.sv
package charpix_pkg;

  // Default geometry of the serializer
  localparam int CHAR_CODE_W = 7;
  localparam int SCAN_ROW_W  = 4;
  localparam int PIX_GROUP   = 8;
  localparam int RST_STAGES  = 2;

  // Operation of the pixel register on a clock edge
  typedef enum logic {
    SR_SHIFT = 1'b0,
    SR_LOAD  = 1'b1
  } sr_op_e;

endpackage

// File: rtl/charpix_rst_sync.sv
module charpix_rst_sync #(
  parameter int STAGES = charpix_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/charpix_row_latch.sv
module charpix_row_latch #(
  parameter int ROW_W = charpix_pkg::SCAN_ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  output logic [ROW_W-1:0] row_q
);

  logic [ROW_W-1:0] row_d;

  always_comb begin
    row_d = row_q;
    if (wr_en) begin
      row_d = wr_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else begin
      row_q <= row_d;
    end
  end

  // R2: a written row appears on the next cycle
  p_row_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> row_q == $past(wr_row));

  // R2: without a write strobe the row is kept
  p_row_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(row_q));

endmodule

// File: rtl/charpix_glyph_rom.sv
module charpix_glyph_rom #(
  parameter int CODE_W = charpix_pkg::CHAR_CODE_W,
  parameter int ROW_W  = charpix_pkg::SCAN_ROW_W,
  parameter int BYTE_W = charpix_pkg::PIX_GROUP
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ROW_W+CODE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic [ROW_W-1:0]        rd_row,
  input  logic [CODE_W-1:0]       rd_code,
  output logic [BYTE_W-1:0]       rd_byte
);

  localparam int ADDR_W = ROW_W + CODE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] rd_addr;

  // Row selects the upper address bits, code the lower ones
  assign rd_addr = {rd_row, rd_code};
  assign rd_byte = mem_q[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  // R1: a stored byte is readable at its address on the next cycle
  p_rom_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/charpix_load_gen.sv
module charpix_load_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic mreq_n,
  input  logic rfsh_n,
  input  logic cpu_clk,
  output logic load_n
);

  logic all_low;

  // Three-input NOR: high only while all three inputs are low
  assign all_low = ~(mreq_n | rfsh_n | cpu_clk);
  // Second NOR stage used as an inverter gives the active-low strobe
  assign load_n  = ~(all_low | 1'b0);

  // R5: a high CPU clock phase never lets a load through
  p_clk_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk |-> load_n);

  // R5: outside a refresh phase no load is made
  p_rfsh_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_n |-> load_n);

  // R5: outside a memory request no load is made
  p_mreq_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> load_n);

endmodule

// File: rtl/charpix_shifter.sv
module charpix_shifter
  import charpix_pkg::*;
#(
  parameter int BYTE_W = charpix_pkg::PIX_GROUP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic [BYTE_W-1:0] par_in,
  output logic              ser_out
);

  localparam int CNT_W = $clog2(BYTE_W) + 1;

  sr_op_e            op;
  logic [BYTE_W-1:0] sr_q;
  logic [BYTE_W-1:0] sr_d;

  always_comb begin
    op = load_n ? SR_SHIFT : SR_LOAD;
    case (op)
      SR_LOAD:  sr_d = par_in;
      default:  sr_d = {sr_q[BYTE_W-2:0], 1'b0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign ser_out = sr_q[BYTE_W-1];

  // R4: a load edge captures the glyph byte
  p_load_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> sr_q == $past(par_in));

  // R6: a non-load edge moves the next lower bit to the output
  p_shift_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> ser_out == $past(sr_q[BYTE_W-2]));

  // Checker state: edges since the last load, saturating at one group
  logic [CNT_W-1:0] since_load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_load_q <= '0;
    end else if (!load_n) begin
      since_load_q <= '0;
    end else if (since_load_q < CNT_W'(BYTE_W)) begin
      since_load_q <= since_load_q + 1'b1;
    end
  end

  // R7: a fully drained register shows white
  p_drained_white_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_load_q >= CNT_W'(BYTE_W)) |-> !ser_out);

endmodule

// File: rtl/charpix_serializer.sv
module charpix_serializer #(
  parameter int CODE_W = charpix_pkg::CHAR_CODE_W,
  parameter int ROW_W  = charpix_pkg::SCAN_ROW_W,
  parameter int BYTE_W = charpix_pkg::PIX_GROUP
) (
  input  logic                    clk_pix,
  input  logic                    rst_n,
  input  logic [CODE_W-1:0]       cpu_data,
  input  logic                    mreq_n,
  input  logic                    rfsh_n,
  input  logic                    cpu_clk,
  input  logic                    row_we,
  input  logic [ROW_W-1:0]        row_wdata,
  input  logic                    rom_we,
  input  logic [ROW_W+CODE_W-1:0] rom_waddr,
  input  logic [BYTE_W-1:0]       rom_wdata,
  output logic                    pix_out
);

  logic              srst_n;
  logic              load_n;
  logic [ROW_W-1:0]  scan_row;
  logic [BYTE_W-1:0] glyph_byte;

  charpix_rst_sync u_rst_sync (
    .clk    (clk_pix),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  charpix_row_latch #(.ROW_W(ROW_W)) u_row_latch (
    .clk    (clk_pix),
    .rst_n  (srst_n),
    .wr_en  (row_we),
    .wr_row (row_wdata),
    .row_q  (scan_row)
  );

  charpix_glyph_rom #(
    .CODE_W (CODE_W),
    .ROW_W  (ROW_W),
    .BYTE_W (BYTE_W)
  ) u_glyph_rom (
    .clk     (clk_pix),
    .rst_n   (srst_n),
    .wr_en   (rom_we),
    .wr_addr (rom_waddr),
    .wr_data (rom_wdata),
    .rd_row  (scan_row),
    .rd_code (cpu_data),
    .rd_byte (glyph_byte)
  );

  charpix_load_gen u_load_gen (
    .clk     (clk_pix),
    .rst_n   (srst_n),
    .mreq_n  (mreq_n),
    .rfsh_n  (rfsh_n),
    .cpu_clk (cpu_clk),
    .load_n  (load_n)
  );

  charpix_shifter #(.BYTE_W(BYTE_W)) u_shifter (
    .clk     (clk_pix),
    .rst_n   (srst_n),
    .load_n  (load_n),
    .par_in  (glyph_byte),
    .ser_out (pix_out)
  );

  // R8: the pixel output is white while reset is applied
  p_reset_white_r8: assert property (@(posedge clk_pix)
    !srst_n |-> !pix_out);

endmodule

// File: tb/tb_charpix_serializer.sv
module tb_charpix_serializer;

  localparam int CODE_W = 7;
  localparam int ROW_W  = 4;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = ROW_W + CODE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CODE_W-1:0] cpu_data;
  logic              mreq_n, rfsh_n, cpu_clk;
  logic              row_we;
  logic [ROW_W-1:0]  row_wdata;
  logic              rom_we;
  logic [ADDR_W-1:0] rom_waddr;
  logic [BYTE_W-1:0] rom_wdata;
  logic              pix_out;

  always #10 clk = ~clk;

  charpix_serializer #(.CODE_W(CODE_W), .ROW_W(ROW_W), .BYTE_W(BYTE_W)) dut (
    .clk_pix(clk), .rst_n(rst_n), .cpu_data(cpu_data), .mreq_n(mreq_n),
    .rfsh_n(rfsh_n), .cpu_clk(cpu_clk), .row_we(row_we), .row_wdata(row_wdata),
    .rom_we(rom_we), .rom_waddr(rom_waddr), .rom_wdata(rom_wdata), .pix_out(pix_out)
  );

  int tests = 0;
  int fails = 0;
  int cyc_cnt = 0;

  logic [BYTE_W-1:0] rom_model [DEPTH];
  logic [BYTE_W-1:0] exp_sr;
  logic [ROW_W-1:0]  row_m;

  typedef struct {
    int    cyc;
    logic  val;
    string tag;
  } item_t;
  item_t sb_q[$];

  function automatic logic [BYTE_W-1:0] glyph_fn(input int a);
    return 8'((a * 37) ^ (a >> 3) ^ 8'h5A);
  endfunction

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: pix_out=%0b expected %0b", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  // Monitor: compares each expected pixel in the cycle it is due
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc == cyc_cnt) begin
      item_t it;
      it = sb_q.pop_front();
      check(pix_out === it.val, it.tag, pix_out, it.val);
    end
  end

  // Driver: one pixel clock of bus activity, expectation pushed for next edge
  task automatic drive(input logic mq, input logic rf, input logic ck,
                       input logic [CODE_W-1:0] code, input bit wr_row,
                       input logic [ROW_W-1:0] new_row, input string tag);
    @(posedge clk); #5;
    mreq_n = mq; rfsh_n = rf; cpu_clk = ck; cpu_data = code;
    row_we = wr_row; row_wdata = new_row; rom_we = 1'b0;
    // R5: load only with all three low; R3: address {row, code}
    if (!mq && !rf && !ck) exp_sr = rom_model[{row_m, code}];
    else                   exp_sr = {exp_sr[BYTE_W-2:0], 1'b0};
    sb_q.push_back('{cyc_cnt + 1, exp_sr[BYTE_W-1], tag});
    if (wr_row) row_m = new_row;
  endtask

  // Fetch cycle of 8 pixel clocks; strobes low in phases 6 and 7
  task automatic fetch(input logic [CODE_W-1:0] code, input bit refresh_ok,
                       input string tag);
    for (int ph = 0; ph < 8; ph++) begin
      logic strobe_n;
      strobe_n = !(ph >= 6);
      drive(strobe_n, refresh_ok ? strobe_n : 1'b1, ph[0], code, 1'b0, '0, tag);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b1, i[0], '0, 1'b0, '0, tag);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, pix_out=%0b expected end of run", pix_out);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mreq_n = 1'b1; rfsh_n = 1'b1; cpu_clk = 1'b1; cpu_data = '0;
    row_we = 1'b0; row_wdata = '0; rom_we = 1'b0; rom_waddr = '0; rom_wdata = '0;
    exp_sr = '0; row_m = '0;
    repeat (3) @(posedge clk);
    #5;
    check(pix_out === 1'b0, "R8 reset output", pix_out, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    check(pix_out === 1'b0, "R8 after reset release", pix_out, 1'b0);

    // R1: fill the whole glyph memory
    for (int a = 0; a < DEPTH; a++) begin
      @(posedge clk); #5;
      rom_we = 1'b1; rom_waddr = ADDR_W'(a); rom_wdata = glyph_fn(a);
      rom_model[a] = glyph_fn(a);
    end
    @(posedge clk); #5;
    rom_we = 1'b0;

    // R4, R6, R9: back-to-back characters on row 0
    fetch(7'h00, 1'b1, "R4 first load");
    fetch(7'h41, 1'b1, "R6/R9 stream");
    fetch(7'h7F, 1'b1, "R3 top code");
    fetch(7'h15, 1'b1, "R9 stream");
    idle(10, "R7 drained white");

    // R2, R3: other scan rows
    drive(1'b1, 1'b1, 1'b0, '0, 1'b1, 4'd5, "R2 row write");
    fetch(7'h41, 1'b1, "R2/R3 row 5");
    fetch(7'h2A, 1'b1, "R3 row 5");
    drive(1'b1, 1'b1, 1'b0, '0, 1'b1, 4'd15, "R2 row write");
    fetch(7'h7F, 1'b1, "R3 row 15 top code");
    fetch(7'h01, 1'b1, "R9 row 15");

    // R5: no load without refresh, or with the CPU clock held high
    fetch(7'h33, 1'b0, "R5 refresh high");
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b0, 1'b1, 7'h44, 1'b0, '0, "R5 cpu_clk high");
    idle(4, "R7 drained white");

    // R1: overwrite one glyph and fetch it
    @(posedge clk); #5;
    rom_we = 1'b1; rom_waddr = {4'd15, 7'h22}; rom_wdata = 8'hC3;
    rom_model[{4'd15, 7'h22}] = 8'hC3;
    exp_sr = {exp_sr[BYTE_W-2:0], 1'b0};
    sb_q.push_back('{cyc_cnt + 1, exp_sr[BYTE_W-1], "R1 write cycle"});
    fetch(7'h22, 1'b1, "R1 rewritten glyph");
    fetch(7'h5E, 1'b1, "R6 stream");

    // R8: reset in mid-character clears output and latch
    drive(1'b1, 1'b1, 1'b0, '0, 1'b0, '0, "R6 partial");
    wait (sb_q.size() == 0);
    #1;
    rst_n = 1'b0;
    #2;
    check(pix_out === 1'b0, "R8 async clear", pix_out, 1'b0);
    repeat (2) @(posedge clk);
    #5;
    rst_n = 1'b1;
    exp_sr = '0; row_m = '0;
    repeat (4) @(posedge clk);
    fetch(7'h41, 1'b1, "R8 row back to 0");
    idle(9, "R7 drained white");

    wait (sb_q.size() == 0);
    @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule